// File: doc/BRIEF.md
# Machine-Cycle Bus Timing Sequencer

This block paces an 8-bit controller's external memory bus from the oscillator clock. It divides time into machine cycles of six states. Each state has two phases, and each phase lasts exactly one clock, so one machine cycle takes twelve clocks. Inside each cycle the block places the address latch pulse, the active-low read, program-read and write strobes, the sampling of returned data and its hand-off to a holding register at fixed state/phase slots. It does this for three cycle kinds: opcode fetch, data read and data write.

The low address byte and the data byte share one multiplexed bus. The high address byte has its own output. A requester presents the cycle kind, the address and the write data, and the block takes them at the boundary between machine cycles. The requester also gives an instruction length in machine cycles. The block counts machine cycles against that length and pulses a done flag at the close of the last one. Decoding, arithmetic and program counter updates are left to the logic around it.

Top module: `mc_bus_seq`

## Requirements
- R1: The state/phase position advances by one phase per clock through S1P1, S1P2, … S6P2 and then wraps to S1P1. `state_o` is 0..5 for S1..S6, and `phase_o` is 0 for P1 and 1 for P2.
- R2: While `rst_ni` is low (asynchronous, active low), the position is S1P1, all strobes are high, `rdata_o` is 0 and `done_o` is 0. The pending request takes its defaults: fetch, address 0, length 1.
- R3: `ale_o` is high in S2P1 only and lasts one clock per machine cycle.
- R4: In a fetch cycle (`cyc_type_i` = 2'b00, and the unused code 2'b11 also acts as fetch), `psen_no` is low from S2P2 through S6P1. `rd_no` and `wr_no` stay high.
- R5: In a data read cycle (2'b01), `rd_no` is low over the same window. `psen_no` and `wr_no` stay high.
- R6: In a data write cycle (2'b10), `wr_no` is low over the same window. `wdata_i` is driven with `ad_oe_o` high from S2P2 through S6P2.
- R7: From S1P1 through S2P1, `ad_o` carries the low address byte with `ad_oe_o` high, for every cycle kind. In fetch and read cycles `ad_oe_o` is low from S2P2 to the end of the cycle. `addr_hi_o` holds the high address byte for the whole cycle.
- R8: In fetch and read cycles, the value on `ad_i` during S3P1 is captured on the clock edge that closes S3P1. It moves to `rdata_o` on the edge that closes S3P2, so it is visible from S4P1. `ad_i` in any other slot, and write cycles, leave `rdata_o` unchanged.
- R9: No more than one of `psen_no`, `rd_no`, `wr_no` is low at any time. All three are high from S1P1 through S2P1 and in S6P2.
- R10: `cyc_type_i`, `addr_i`, `wdata_i` are taken only on the edge that closes S6P2, and they apply to the next machine cycle. Changing them at any other time has no effect on the outputs.
- R11: `done_o` is high for one clock, in S6P2 of the last machine cycle of an instruction. `len_i` is taken on the edge that closes that pulse and sets the next instruction's length. A length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one phase per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_type_i | input | 2 | Next cycle kind: 00 fetch, 01 read, 10 write, 11 fetch |
| addr_i | input | 16 | Next cycle address |
| wdata_i | input | 8 | Next cycle write byte |
| len_i | input | 3 | Next instruction length in machine cycles |
| ad_i | input | 8 | Multiplexed bus, incoming data |
| state_o | output | 3 | Current state, 0..5 = S1..S6 |
| phase_o | output | 1 | Current phase, 0 = P1, 1 = P2 |
| ale_o | output | 1 | Address latch pulse |
| psen_no | output | 1 | Program-memory read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Multiplexed bus, outgoing address/data |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| addr_hi_o | output | 8 | High address byte |
| rdata_o | output | 8 | Last captured opcode or read byte |
| done_o | output | 1 | Instruction complete pulse |

## Verification
The strobe, latch pulse and bus outputs are decoded from registered position and request state, so each one is due in the same phase the requirement names. The bench samples them at the falling edge inside every one of the twelve phases of a cycle. The captured byte goes through two registers: it is presented on `ad_i` only in S3P1 and is expected on `rdata_o` from S4P1, with the previous value expected in every earlier phase. New requests and lengths are applied in S6P2 and checked one clock later in S1P1. Deliberate junk is driven in S4P1 to show that it is ignored.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int MC_STATES  = 6;
  localparam int MC_PHASES  = 2;
  localparam int MC_SLOTS   = MC_STATES * MC_PHASES;
  localparam int MC_STATE_W = $clog2(MC_STATES);
  localparam int MC_SLOT_W  = MC_STATE_W + 1;

  // slot = state * 2 + phase
  localparam int SLOT_ALE   = 1 * MC_PHASES + 0;  // S2P1
  localparam int SLOT_STB_A = 1 * MC_PHASES + 1;  // S2P2
  localparam int SLOT_STB_Z = 5 * MC_PHASES + 0;  // S6P1
  localparam int SLOT_SMP   = 2 * MC_PHASES + 0;  // S3P1
  localparam int SLOT_LAT   = 2 * MC_PHASES + 1;  // S3P2
  localparam int SLOT_LAST  = MC_SLOTS - 1;       // S6P2

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_RSVD  = 2'b11
  } cyc_e;
endpackage

// File: rtl/mc_slot_ctr.sv
module mc_slot_ctr
  import mc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [MC_STATE_W-1:0] state_o,
  output logic                  phase_o,
  output logic [MC_SLOT_W-1:0]  slot_o,
  output logic                  last_o
);
  localparam logic [MC_STATE_W-1:0] STATE_MAX = MC_STATE_W'(MC_STATES - 1);

  logic [MC_STATE_W-1:0] state_q;
  logic                  phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) state_q <= (state_q == STATE_MAX) ? '0 : state_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign slot_o  = {state_q, phase_q};
  assign last_o  = (state_q == STATE_MAX) && phase_q;

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (slot_o == '0)); // R1
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> (slot_o == $past(slot_o) + 1'b1)); // R1
endmodule

// File: rtl/mc_bus_ctl.sv
module mc_bus_ctl
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MC_SLOT_W-1:0] slot_i,
  input  cyc_e                 cyc_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [DATA_W-1:0]    ad_i,
  output logic                 ale_o,
  output logic                 psen_no,
  output logic                 rd_no,
  output logic                 wr_no,
  output logic [DATA_W-1:0]    ad_o,
  output logic                 ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [MC_SLOT_W-1:0] S_ALE   = MC_SLOT_W'(SLOT_ALE);
  localparam logic [MC_SLOT_W-1:0] S_STB_A = MC_SLOT_W'(SLOT_STB_A);
  localparam logic [MC_SLOT_W-1:0] S_STB_Z = MC_SLOT_W'(SLOT_STB_Z);
  localparam logic [MC_SLOT_W-1:0] S_SMP   = MC_SLOT_W'(SLOT_SMP);
  localparam logic [MC_SLOT_W-1:0] S_LAT   = MC_SLOT_W'(SLOT_LAT);
  localparam logic [MC_SLOT_W-1:0] S_LAST  = MC_SLOT_W'(SLOT_LAST);

  logic is_wr, is_rd, is_fe, stb_win, addr_ph;
  logic [DATA_W-1:0] smp_q, rdata_q;

  assign is_wr   = (cyc_i == CYC_WRITE);
  assign is_rd   = (cyc_i == CYC_READ);
  assign is_fe   = !is_wr && !is_rd;
  assign stb_win = (slot_i >= S_STB_A) && (slot_i <= S_STB_Z);
  assign addr_ph = (slot_i <= S_ALE);

  assign ale_o     = (slot_i == S_ALE);
  assign psen_no   = !(stb_win && is_fe);
  assign rd_no     = !(stb_win && is_rd);
  assign wr_no     = !(stb_win && is_wr);
  assign ad_oe_o   = addr_ph || is_wr;
  assign ad_o      = addr_ph ? addr_i[DATA_W-1:0] : wdata_i;
  assign addr_hi_o = addr_i[ADDR_W-1:DATA_W];
  assign rdata_o   = rdata_q;

  // two-step capture: sample at end of S3P1, present at end of S3P2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q   <= '0;
      rdata_q <= '0;
    end else if (!is_wr) begin
      if (slot_i == S_SMP) smp_q   <= ad_i;
      if (slot_i == S_LAT) rdata_q <= smp_q;
    end
  end

  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R3
  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_no, ~rd_no, ~wr_no}) <= 1); // R9
  AST_STB_IDLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == S_LAST) |-> (psen_no && rd_no && wr_no)); // R9
  AST_WR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != S_LAT) |=> $stable(rdata_o)); // R8
endmodule

// File: rtl/mc_instr_ctr.sv
module mc_instr_ctr #(
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             last_slot_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             last_mc;

  assign last_mc = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_q};
  assign done_o  = last_slot_i && last_mc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= LEN_W'(1);
    end else if (last_slot_i) begin
      if (last_mc) begin
        cnt_q <= '0;
        len_q <= (len_i == '0) ? LEN_W'(1) : len_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_q); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

// File: rtl/mc_bus_seq.sv
module mc_bus_seq
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               cyc_type_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [MC_STATE_W-1:0]    state_o,
  output logic                     phase_o,
  output logic                     ale_o,
  output logic                     psen_no,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  logic [MC_SLOT_W-1:0] slot;
  logic                 last;
  cyc_e                 cyc_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;

  mc_slot_ctr i_slot (
    .clk_i, .rst_ni,
    .state_o, .phase_o,
    .slot_o (slot),
    .last_o (last)
  );

  // request is taken only at the cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (last) begin
      cyc_q   <= cyc_e'(cyc_type_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  mc_bus_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
    .clk_i, .rst_ni,
    .slot_i  (slot),
    .cyc_i   (cyc_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .ad_i, .ale_o, .psen_no, .rd_no, .wr_no,
    .ad_o, .ad_oe_o, .addr_hi_o, .rdata_o
  );

  mc_instr_ctr #(.LEN_W(LEN_W)) i_instr (
    .clk_i, .rst_ni,
    .last_slot_i (last),
    .len_i,
    .done_o
  );

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable({cyc_q, addr_q, wdata_q})); // R10
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_o == MC_STATE_W'(MC_STATES - 1)) && phase_o); // R11
  AST_ALE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o && (ad_o == addr_q[DATA_W-1:0])); // R7
endmodule

// File: tb/test_mc_bus_seq.sv
module test_mc_bus_seq;
  localparam logic [1:0] F = 2'b00, RD = 2'b01, WR = 2'b10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cyc_type_i = F;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  len_i = 3'd1;
  logic [7:0]  ad_i = '0;
  logic [2:0]  state_o;
  logic        phase_o, ale_o, psen_no, rd_no, wr_no, ad_oe_o, done_o;
  logic [7:0]  ad_o, addr_hi_o, rdata_o;

  int checks = 0, errors = 0;
  logic [7:0] prev_rd = '0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  mc_bus_seq i_mc_bus_seq (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // entry: negedge in S1P1 of the cycle; exit: negedge in S1P1 of the next one
  task automatic mcycle(input logic [1:0] ty, input logic [15:0] ad, input logic [7:0] wd,
                        input logic [7:0] rdv, input bit exp_done,
                        input logic [1:0] n_ty, input logic [15:0] n_ad,
                        input logic [7:0] n_wd, input logic [2:0] n_len);
    for (int s = 0; s < 12; s++) begin
      bit       addr_ph = (s <= 2);
      bit       win = (s >= 3) && (s <= 10);
      bit       is_w = (ty == WR), is_r = (ty == RD), is_f = !is_w && !is_r;
      logic       e_oe = addr_ph || is_w;
      logic [7:0] e_rd = (s >= 6 && !is_w) ? rdv : prev_rd;
      ad_i = (s == 4) ? rdv : ~rdv;
      chk({state_o, phase_o} == {3'(s / 2), 1'(s % 2)}, "R1 position",
          {state_o, phase_o}, {3'(s / 2), 1'(s % 2)});
      chk(ale_o == (s == 2), "R3 ale", ale_o, (s == 2));
      chk(psen_no == !(win && is_f), "R4 psen_n", psen_no, !(win && is_f));
      chk(rd_no == !(win && is_r), "R5 rd_n", rd_no, !(win && is_r));
      chk(wr_no == !(win && is_w), "R6 wr_n", wr_no, !(win && is_w));
      chk(ad_oe_o == e_oe, "R7 ad_oe", ad_oe_o, e_oe);
      if (e_oe) chk(ad_o == (addr_ph ? ad[7:0] : wd), "R7 ad_o", ad_o, addr_ph ? ad[7:0] : wd);
      chk(addr_hi_o == ad[15:8], "R7 addr_hi", addr_hi_o, ad[15:8]);
      chk(rdata_o == e_rd, "R8 rdata", rdata_o, e_rd);
      chk(done_o == (exp_done && s == 11), "R11 done", done_o, (exp_done && s == 11));
      if (s <= 2 || s == 11)
        chk(psen_no && rd_no && wr_no, "R9 strobes idle", {psen_no, rd_no, wr_no}, 3'b111);
      if (s == 6) begin  // junk on request inputs: R10
        cyc_type_i = ~n_ty; addr_i = ~ad; wdata_i = ~wd; len_i = ~n_len;
      end
      if (s == 11) begin
        cyc_type_i = n_ty; addr_i = n_ad; wdata_i = n_wd; len_i = n_len;
      end
      @(negedge clk_i);
    end
    if (ty != WR) prev_rd = rdv;
  endtask

  task automatic reset_mid;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk({state_o, phase_o} == 4'h0, "R2 position", {state_o, phase_o}, 4'h0);
    chk(psen_no && rd_no && wr_no, "R2 strobes", {psen_no, rd_no, wr_no}, 3'b111);
    chk(rdata_o == 8'h00, "R2 rdata", rdata_o, 8'h00);
    chk(!done_o && !ale_o, "R2 done/ale", {done_o, ale_o}, 2'b00);
    chk(addr_hi_o == 8'h00, "R2 request default", addr_hi_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_rd = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({state_o, phase_o} == 4'h0, "R2 position", {state_o, phase_o}, 4'h0);
    chk(psen_no && rd_no && wr_no, "R2 strobes", {psen_no, rd_no, wr_no}, 3'b111);
    chk(rdata_o == 8'h00, "R2 rdata", rdata_o, 8'h00);
    rst_ni = 1'b1;
    mcycle(F,  16'h0000, 8'h00, 8'h74, 1, F,  16'h1234, 8'h00, 3'd1);
    mcycle(F,  16'h1234, 8'h00, 8'hA5, 1, F,  16'h0100, 8'h00, 3'd4);
    mcycle(F,  16'h0100, 8'h00, 8'h6B, 0, RD, 16'h80C3, 8'h00, 3'd1);
    mcycle(RD, 16'h80C3, 8'h00, 8'h3C, 0, WR, 16'h4455, 8'h99, 3'd1);
    mcycle(WR, 16'h4455, 8'h99, 8'h12, 0, F,  16'h0101, 8'h00, 3'd1);
    mcycle(F,  16'h0101, 8'h00, 8'hE1, 1, F,  16'h0200, 8'h00, 3'd0);
    mcycle(F,  16'h0200, 8'h00, 8'h5A, 1, 2'b11, 16'h0201, 8'h00, 3'd2);
    mcycle(F,  16'h0201, 8'h00, 8'hC7, 0, WR, 16'h00FF, 8'h00, 3'd1);
    mcycle(WR, 16'h00FF, 8'h00, 8'hFF, 1, RD, 16'hFFFF, 8'h00, 3'd1);
    mcycle(RD, 16'hFFFF, 8'h00, 8'h81, 1, F,  16'h0300, 8'h00, 3'd3);
    reset_mid();
    mcycle(F,  16'h0000, 8'h00, 8'h96, 1, F,  16'h0000, 8'h00, 3'd1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule